// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block follows one processor core through its power states. The core starts in the running state. From there, a halt pulse, a wait-instruction pulse or a level-2 register read sends it into one of three powerdown states: halt-powerdown, wait-powerdown or deep sleep. Interrupt-class wake events bring it back to running. A monitor event is a further wake source, but only for wait-powerdown.

While the core is powered down, two things can take it out of its state for a while. A snoop request sends it to a serviceable sub-state. A stop-clock request sends it to a stop-grant state. When the snoop completes, or the stop-clock request drops, the core goes back to exactly the state it left. A one-cycle stop-grant acknowledge pulse is issued when the core enters a stop-grant or deep-sleep state while stop-clock is asserted. A clock-gate enable tells the surrounding logic when the core's clocks may be stopped.

States and their encodings: RUN=0, HALT=1, MWAIT=2, C2=3, SNOOP=4, STOPGRANT=5.

Transitions:
- Entry: RUN→HALT, RUN→MWAIT and RUN→C2.
- Wake: HALT→RUN, MWAIT→RUN and C2→RUN.
- Stop-clock: HALT→STOPGRANT and MWAIT→STOPGRANT.
- Snoop: HALT, MWAIT or C2→SNOOP.
- Return: SNOOP→origin and STOPGRANT→origin.
- Reset: any state→RUN.

Top module: `core_pstate_ctrl`

## Requirements
- R1: After reset, `pstate` is RUN (0), and `stopgnt_ack`, `snp_svc` and `clk_gate_en` are all low.
- R2: In RUN, the state changes at the next clock edge as follows. `lvl2_rd`, or `mwait_req` with `mwait_deep`, moves it to C2 (3). Otherwise `mwait_req` moves it to MWAIT (2). Otherwise `halt_req` moves it to HALT (1). The priority order is C2, then MWAIT, then HALT.
- R3: In HALT, MWAIT or C2, any of `wake_smi`, `wake_init`, `wake_nmi`, `wake_intr` or `wake_msg` moves the core to RUN at the next edge.
- R4: `monitor_evt` wakes MWAIT to RUN. It has no effect in HALT or C2.
- R5: With `stpclk_req` high in HALT or MWAIT, the core moves to STOPGRANT (5). When `stpclk_req` goes low, the core returns to the state it came from.
- R6: A snoop in HALT, MWAIT or C2 moves the core to SNOOP (4), where `snp_svc` is high. When `snp_done` is high in SNOOP, the core returns to the exact originating state.
- R7: With DUAL_CORE=1, both `snp_bus` and `snp_peer` start a snoop. With DUAL_CORE=0, only `snp_bus` starts one, and `snp_peer` is ignored.
- R8: `stopgnt_ack` is high for exactly one cycle. That cycle is the first cycle in STOPGRANT or C2, and only when `stpclk_req` was high at the entering edge.
- R9: While `stpclk_req` stays high, a re-entry to C2 (for example, after a snoop) issues no further acknowledge.
- R10: `clk_gate_en` is high in HALT, MWAIT, C2 and STOPGRANT. It is low in RUN and SNOOP, and low in any powerdown cycle that has a wake event present.
- R11: A wake event takes priority over a snoop and over a stop-clock request in the same cycle.
- R12: Entry pulses are ignored outside RUN. In STOPGRANT, wake events and snoops have no effect.
- R13: Asserting `rst_n` low forces RUN immediately, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt instruction pulse |
| mwait_req | input | 1 | Wait instruction pulse |
| mwait_deep | input | 1 | Deep-sleep hint qualifying `mwait_req` |
| lvl2_rd | input | 1 | Level-2 register read pulse |
| wake_smi | input | 1 | System management interrupt |
| wake_init | input | 1 | Init request |
| wake_nmi | input | 1 | Non-maskable interrupt |
| wake_intr | input | 1 | Maskable interrupt |
| wake_msg | input | 1 | Bus interrupt message |
| monitor_evt | input | 1 | Monitored-address write event |
| stpclk_req | input | 1 | Stop-clock request level |
| snp_bus | input | 1 | Snoop from the bus |
| snp_peer | input | 1 | Snoop from the other core |
| snp_done | input | 1 | Snoop service complete |
| pstate | output | 3 | Current state encoding |
| stopgnt_ack | output | 1 | Stop-grant acknowledge pulse |
| snp_svc | output | 1 | Snoop being serviced |
| clk_gate_en | output | 1 | Clock gating allowed |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:

- **Snoop return.** It checks that the core returns to its exact originating state after a snoop or a stop-grant. A design that always returned to HALT would leave MWAIT or C2 in the wrong place.
- **Monitor event.** It checks that the monitor event wakes only MWAIT. A design that wired the event into the common wake set would wake HALT as well.
- **Repeated acknowledge.** It holds stop-clock high across a C2→SNOOP→C2 round trip. A design without the sent flag would pulse the acknowledge twice.
- **Wake priority.** It drives a wake together with a snoop, and checks `clk_gate_en` in that wake cycle. A design with the priority reversed would enter SNOOP instead of RUN.
- **Single-core variant.** A second, single-core instance must ignore the peer-core snoop.

// File: rtl/core_pstate_pkg.sv
package core_pstate_pkg;

    localparam int unsigned PS_W = 3;

    typedef enum logic [PS_W-1:0] {
        PS_RUN       = 3'd0,
        PS_HALT      = 3'd1,
        PS_MWAIT     = 3'd2,
        PS_C2        = 3'd3,
        PS_SNOOP     = 3'd4,
        PS_STOPGRANT = 3'd5
    } pstate_e;

endpackage

// File: rtl/core_pstate_evt.sv
module core_pstate_evt #(
    parameter bit DUAL_CORE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_smi,
    input  logic wake_init,
    input  logic wake_nmi,
    input  logic wake_intr,
    input  logic wake_msg,
    input  logic snp_bus,
    input  logic snp_peer,
    output logic wake_any,
    output logic snp_any
);

    assign wake_any = wake_smi | wake_init | wake_nmi | wake_intr | wake_msg;

    generate
        if (DUAL_CORE) begin : g_dual
            assign snp_any = snp_bus | snp_peer;
        end else begin : g_single
            assign snp_any = snp_bus;
            // R7
            peer_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (snp_peer && !snp_bus) |-> !snp_any);
        end
    endgenerate

endmodule

// File: rtl/core_pstate_ack.sv
module core_pstate_ack
    import core_pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e cur_st,
    input  pstate_e nxt_st,
    input  logic    stpclk_req,
    output logic    ack
);

    logic sent_q;
    logic enter_gnt;

    assign enter_gnt = (nxt_st != cur_st) &&
                       ((nxt_st == PS_STOPGRANT) || (nxt_st == PS_C2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            sent_q <= 1'b0;
        end else begin
            ack <= enter_gnt && stpclk_req && !sent_q;
            if (!stpclk_req) begin
                sent_q <= 1'b0;
            end else if (enter_gnt) begin
                sent_q <= 1'b1;
            end
        end
    end

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R8
    ack_needs_stpclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(stpclk_req));
    // R9
    ack_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && stpclk_req) |=> !ack);

endmodule

// File: rtl/core_pstate_fsm.sv
module core_pstate_fsm
    import core_pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_req,
    input  logic    mwait_req,
    input  logic    mwait_deep,
    input  logic    lvl2_rd,
    input  logic    wake_any,
    input  logic    monitor_evt,
    input  logic    stpclk_req,
    input  logic    snp_any,
    input  logic    snp_done,
    output pstate_e cur_st,
    output pstate_e nxt_st,
    output logic    wake_now,
    output logic    gate_en
);

    pstate_e st_q;
    pstate_e ret_q;
    pstate_e st_d;

    // next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_RUN: begin
                if (lvl2_rd || (mwait_req && mwait_deep)) st_d = PS_C2;
                else if (mwait_req)                       st_d = PS_MWAIT;
                else if (halt_req)                        st_d = PS_HALT;
            end
            PS_HALT: begin
                if (wake_any)        st_d = PS_RUN;
                else if (stpclk_req) st_d = PS_STOPGRANT;
                else if (snp_any)    st_d = PS_SNOOP;
            end
            PS_MWAIT: begin
                if (wake_any || monitor_evt) st_d = PS_RUN;
                else if (stpclk_req)         st_d = PS_STOPGRANT;
                else if (snp_any)            st_d = PS_SNOOP;
            end
            PS_C2: begin
                if (wake_any)     st_d = PS_RUN;
                else if (snp_any) st_d = PS_SNOOP;
            end
            PS_SNOOP: begin
                if (snp_done) st_d = ret_q;
            end
            PS_STOPGRANT: begin
                if (!stpclk_req) st_d = ret_q;
            end
            default: st_d = PS_RUN;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_RUN;
            ret_q <= PS_HALT;
        end else begin
            st_q <= st_d;
            if ((st_d == PS_SNOOP || st_d == PS_STOPGRANT) && st_q != st_d) begin
                ret_q <= st_q;
            end
        end
    end

    // output process
    always_comb begin
        wake_now = 1'b0;
        gate_en  = 1'b0;
        unique case (st_q)
            PS_HALT, PS_C2: begin
                wake_now = wake_any;
                gate_en  = !wake_any;
            end
            PS_MWAIT: begin
                wake_now = wake_any || monitor_evt;
                gate_en  = !(wake_any || monitor_evt);
            end
            PS_STOPGRANT: gate_en = 1'b1;
            PS_RUN, PS_SNOOP: gate_en = 1'b0;
            default: gate_en = 1'b0;
        endcase
    end

    assign cur_st = st_q;
    assign nxt_st = st_d;

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_RUN && halt_req && !mwait_req && !lvl2_rd) |=> st_q == PS_HALT);
    // R3
    wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_now |=> st_q == PS_RUN);
    // R5
    stopgrant_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_STOPGRANT && !stpclk_req) |=> st_q == $past(ret_q));
    // R6
    snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SNOOP && snp_done) |=> st_q == $past(ret_q));
    // R6
    ret_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_SNOOP) |-> (ret_q == PS_HALT || ret_q == PS_MWAIT || ret_q == PS_C2));
    // R12
    stopgrant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_STOPGRANT && stpclk_req) |=> st_q == PS_STOPGRANT);

endmodule

// File: rtl/core_pstate_ctrl.sv
module core_pstate_ctrl
    import core_pstate_pkg::*;
#(
    parameter bit DUAL_CORE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic            mwait_req,
    input  logic            mwait_deep,
    input  logic            lvl2_rd,
    input  logic            wake_smi,
    input  logic            wake_init,
    input  logic            wake_nmi,
    input  logic            wake_intr,
    input  logic            wake_msg,
    input  logic            monitor_evt,
    input  logic            stpclk_req,
    input  logic            snp_bus,
    input  logic            snp_peer,
    input  logic            snp_done,
    output logic [PS_W-1:0] pstate,
    output logic            stopgnt_ack,
    output logic            snp_svc,
    output logic            clk_gate_en
);

    logic    wake_any;
    logic    snp_any;
    logic    wake_now;
    pstate_e cur_st;
    pstate_e nxt_st;

    core_pstate_evt #(.DUAL_CORE(DUAL_CORE)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_smi  (wake_smi),
        .wake_init (wake_init),
        .wake_nmi  (wake_nmi),
        .wake_intr (wake_intr),
        .wake_msg  (wake_msg),
        .snp_bus   (snp_bus),
        .snp_peer  (snp_peer),
        .wake_any  (wake_any),
        .snp_any   (snp_any)
    );

    core_pstate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .mwait_req   (mwait_req),
        .mwait_deep  (mwait_deep),
        .lvl2_rd     (lvl2_rd),
        .wake_any    (wake_any),
        .monitor_evt (monitor_evt),
        .stpclk_req  (stpclk_req),
        .snp_any     (snp_any),
        .snp_done    (snp_done),
        .cur_st      (cur_st),
        .nxt_st      (nxt_st),
        .wake_now    (wake_now),
        .gate_en     (clk_gate_en)
    );

    core_pstate_ack u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_st     (cur_st),
        .nxt_st     (nxt_st),
        .stpclk_req (stpclk_req),
        .ack        (stopgnt_ack)
    );

    assign pstate  = cur_st;
    assign snp_svc = (cur_st == PS_SNOOP);

    // R10
    gate_low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 3'd0 || snp_svc) |-> !clk_gate_en);
    // R11
    wake_over_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_now && snp_any) |=> !snp_svc);
    // R10
    wake_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_now |-> !clk_gate_en);

endmodule

// File: tb/core_pstate_ctrl_bench.sv
module core_pstate_ctrl_bench;

    localparam int B_HALT = 0, B_MWAIT = 1, B_DEEP = 2, B_LVL2 = 3, B_SMI = 4,
                   B_INIT = 5, B_NMI = 6, B_INTR = 7, B_MSG = 8, B_MON = 9,
                   B_STP = 10, B_SBUS = 11, B_SPEER = 12, B_DONE = 13, B_RST = 14;

    localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_MW = 3'd2, S_C2 = 3'd3,
                           S_SNP = 3'd4, S_SG = 3'd5;

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic       ack;
        logic       gate;
        logic [2:0] st1;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [14:0] v = '0;
    logic [2:0] ps_d, ps_s;
    logic ack_d, ack_s, svc_d, svc_s, gate_d, gate_s;
    exp_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    core_pstate_ctrl #(.DUAL_CORE(1'b1)) u_core_pstate_ctrl (
        .clk(clk), .rst_n(rst_n & ~v[B_RST]),
        .halt_req(v[B_HALT]), .mwait_req(v[B_MWAIT]), .mwait_deep(v[B_DEEP]),
        .lvl2_rd(v[B_LVL2]), .wake_smi(v[B_SMI]), .wake_init(v[B_INIT]),
        .wake_nmi(v[B_NMI]), .wake_intr(v[B_INTR]), .wake_msg(v[B_MSG]),
        .monitor_evt(v[B_MON]), .stpclk_req(v[B_STP]), .snp_bus(v[B_SBUS]),
        .snp_peer(v[B_SPEER]), .snp_done(v[B_DONE]),
        .pstate(ps_d), .stopgnt_ack(ack_d), .snp_svc(svc_d), .clk_gate_en(gate_d));

    core_pstate_ctrl #(.DUAL_CORE(1'b0)) u_single (
        .clk(clk), .rst_n(rst_n & ~v[B_RST]),
        .halt_req(v[B_HALT]), .mwait_req(v[B_MWAIT]), .mwait_deep(v[B_DEEP]),
        .lvl2_rd(v[B_LVL2]), .wake_smi(v[B_SMI]), .wake_init(v[B_INIT]),
        .wake_nmi(v[B_NMI]), .wake_intr(v[B_INTR]), .wake_msg(v[B_MSG]),
        .monitor_evt(v[B_MON]), .stpclk_req(v[B_STP]), .snp_bus(v[B_SBUS]),
        .snp_peer(v[B_SPEER]), .snp_done(v[B_DONE]),
        .pstate(ps_s), .stopgnt_ack(ack_s), .snp_svc(svc_s), .clk_gate_en(gate_s));

    // driver: apply inputs for one cycle and queue what this cycle must show
    task automatic step(input string tag, input logic [14:0] vin, input logic [2:0] es,
                        input logic ea, input logic eg, input logic [2:0] es1);
        exp_t e;
        @(negedge clk);
        v = vin;
        e.tag = tag; e.st = es; e.ack = ea; e.gate = eg; e.st1 = es1;
        q.push_back(e);
    endtask

    function automatic logic [14:0] b(input int i);
        return 15'(1) << i;
    endfunction

    task automatic miss(input string tag, input string what, input int act, input int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    // monitor: compare in the middle of the low phase
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (ps_d !== e.st)   miss(e.tag, "pstate", int'(ps_d), int'(e.st));
                if (ack_d !== e.ack) miss(e.tag, "stopgnt_ack", int'(ack_d), int'(e.ack));
                if (gate_d !== e.gate) miss(e.tag, "clk_gate_en", int'(gate_d), int'(e.gate));
                if (svc_d !== (e.st == S_SNP)) miss(e.tag, "snp_svc", int'(svc_d), int'(e.st == S_SNP));
                if (ps_s !== e.st1)  miss(e.tag, "pstate_single", int'(ps_s), int'(e.st1));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset idle",        '0,                 S_RUN, 0, 0, S_RUN);
        step("R2 halt req",          b(B_HALT),          S_RUN, 0, 0, S_RUN);
        step("R2 in halt",           '0,                 S_HALT, 0, 1, S_HALT);
        step("R6 bus snoop",         b(B_SBUS),          S_HALT, 0, 1, S_HALT);
        step("R6 servicing",         '0,                 S_SNP, 0, 0, S_SNP);
        step("R6 snoop done",        b(B_DONE),          S_SNP, 0, 0, S_SNP);
        step("R6 back to halt",      '0,                 S_HALT, 0, 1, S_HALT);
        step("R4 monitor in halt",   b(B_MON),           S_HALT, 0, 1, S_HALT);
        step("R4 halt kept",         '0,                 S_HALT, 0, 1, S_HALT);
        step("R3 R10 intr wake",     b(B_INTR),          S_HALT, 0, 0, S_HALT);
        step("R2 mwait req",         b(B_MWAIT),         S_RUN, 0, 0, S_RUN);
        step("R2 in mwait",          '0,                 S_MW, 0, 1, S_MW);
        step("R5 stpclk in mwait",   b(B_STP),           S_MW, 0, 1, S_MW);
        step("R8 stopgrant ack",     b(B_STP),           S_SG, 1, 1, S_SG);
        step("R12 stopgrant ignores", b(B_STP)|b(B_SMI)|b(B_SBUS), S_SG, 0, 1, S_SG);
        step("R5 stpclk drops",      '0,                 S_SG, 0, 1, S_SG);
        step("R5 back to mwait",     '0,                 S_MW, 0, 1, S_MW);
        step("R7 peer snoop",        b(B_SPEER),         S_MW, 0, 1, S_MW);
        step("R7 dual snoops",       '0,                 S_SNP, 0, 0, S_MW);
        step("R7 done",              b(B_DONE),          S_SNP, 0, 0, S_MW);
        step("R6 back to mwait",     '0,                 S_MW, 0, 1, S_MW);
        step("R4 R11 monitor+snoop", b(B_MON)|b(B_SBUS), S_MW, 0, 0, S_MW);
        step("R2 lvl2 with stpclk",  b(B_LVL2)|b(B_STP), S_RUN, 0, 0, S_RUN);
        step("R8 c2 ack",            b(B_STP),           S_C2, 1, 1, S_C2);
        step("R6 snoop in c2",       b(B_STP)|b(B_SBUS), S_C2, 0, 1, S_C2);
        step("R6 servicing c2",      b(B_STP),           S_SNP, 0, 0, S_SNP);
        step("R6 done c2",           b(B_STP)|b(B_DONE), S_SNP, 0, 0, S_SNP);
        step("R9 no repeat ack",     b(B_STP),           S_C2, 0, 1, S_C2);
        step("R12 halt in c2",       b(B_STP)|b(B_HALT), S_C2, 0, 1, S_C2);
        step("R12 c2 kept",          '0,                 S_C2, 0, 1, S_C2);
        step("R3 msg wake c2",       b(B_MSG),           S_C2, 0, 0, S_C2);
        step("R2 deep mwait",        b(B_MWAIT)|b(B_DEEP), S_RUN, 0, 0, S_RUN);
        step("R8 c2 no stpclk",      '0,                 S_C2, 0, 1, S_C2);
        step("R11 init+snoop",       b(B_INIT)|b(B_SBUS), S_C2, 0, 0, S_C2);
        step("R2 mwait over halt",   b(B_HALT)|b(B_MWAIT), S_RUN, 0, 0, S_RUN);
        step("R2 mwait won",         '0,                 S_MW, 0, 1, S_MW);
        step("R3 nmi wake",          b(B_NMI),           S_MW, 0, 0, S_MW);
        step("R2 halt again",        b(B_HALT),          S_RUN, 0, 0, S_RUN);
        step("R5 stpclk in halt",    b(B_STP),           S_HALT, 0, 1, S_HALT);
        step("R8 ack again",         b(B_STP),           S_SG, 1, 1, S_SG);
        step("R5 drop",              '0,                 S_SG, 0, 1, S_SG);
        step("R5 back to halt",      '0,                 S_HALT, 0, 1, S_HALT);
        step("R3 smi wake",          b(B_SMI),           S_HALT, 0, 0, S_HALT);
        step("R2 lvl2",              b(B_LVL2),          S_RUN, 0, 0, S_RUN);
        step("R8 c2 quiet",          '0,                 S_C2, 0, 1, S_C2);
        step("R13 reset in c2",      b(B_RST),           S_RUN, 0, 0, S_RUN);
        step("R13 run after reset",  '0,                 S_RUN, 0, 0, S_RUN);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule